// File: doc/BRIEF.md
# Synchronous Serial Port Controller (Master/Slave, 8-bit)

This block moves one byte at a time over a four-wire synchronous serial link and can play either end of it. As the clock-generating side it drives the serial clock and outgoing data and samples the incoming line. As the responding side it follows an external clock that is only honoured while its select input is held low. A processor reaches it through three byte-wide registers: control, status and data.

Software picks the idle clock level, which clock edge samples data, the bit order and the role. In the clock-generating role it also picks the clock rate from a two-bit rate code combined with a double-speed bit. Writing the data register loads the shift register and, in the clock-generating role, starts the byte. Reading the data register returns the last byte received. A completion flag and a collision flag report progress; the completion flag, gated by an enable bit, forms the interrupt request. If the select input is pulled low while the block is generating the clock, the block yields: it drops to the responding role and raises the completion flag.

Top module: `spi_duplex_unit`

## Requirements
- R1: In master role `sckOut` rests at the clock-polarity bit (control bit 1) whenever no byte is being shifted, and `sckOe` and `mosiOe` are 1; in slave role they are 0.
- R2: With clock-phase bit (control bit 0) at 0, each bit is sampled on the leading clock edge (the edge leaving the idle level) and the next bit is set up on the trailing edge; with the bit at 1, setup is on the leading edge and sampling on the trailing edge. This holds in both roles.
- R3: The master half-period of SCK, in clock cycles, is 2, 8, 32 or 64 for rate codes (control bits 6:5) 0, 1, 2, 3 when the double-speed bit (status bit 2) is 0, and 1, 4, 16 or 32 when it is 1. This corresponds to SCK = clk/4, /16, /64, /128 and clk/2, /8, /32, /64.
- R4: Control bit 3 at 0 shifts the most significant bit first; at 1, the least significant bit first. This applies to both the transmitted and the received byte.
- R5: A write to the data register (address 2) while no transfer is in progress loads the byte to send and, in master role, starts a transfer. A read of the data register returns the last completed received byte.
- R6: The completion flag (status bit 0) becomes 1 after the 16th SCK edge of a byte, in either role.
- R7: A write to the data register while a transfer is in progress sets the collision flag (status bit 1) and leaves the byte being shifted unchanged.
- R8: Each flag is cleared only by a read of the status register (address 1) that sees the flag set, followed by a read or write of the data register. A data access with no such status read leaves the flag set.
- R9: `irq` equals completion flag AND interrupt-enable bit (control bit 4); a one-cycle `irqAck` pulse clears the completion flag.
- R10: When the synchronized `ssN` is low in master role (control bit 2 = 1), the master bit clears, any transfer stops and the completion flag is set.
- R11: In slave role a transfer is in progress only while `ssN` is low. Taking `ssN` high mid-byte discards the partial byte: it sets no flag, and the next byte is counted from its first edge.
- R12: After reset the control register (address 0), the status register and `irq` read 0, and the block is in slave role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register select: 0 control, 1 status, 2 data |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (triggers read side effects) |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr` |
| irqAck | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt request |
| sckIn | input | 1 | Serial clock from a remote master |
| sckOut | output | 1 | Serial clock driven in master role |
| sckOe | output | 1 | Output enable for `sckOut` |
| mosiIn | input | 1 | Master-to-slave data seen in slave role |
| mosiOut | output | 1 | Master-to-slave data driven in master role |
| mosiOe | output | 1 | Output enable for `mosiOut` |
| misoIn | input | 1 | Slave-to-master data seen in master role |
| misoOut | output | 1 | Slave-to-master data driven in slave role |
| misoOe | output | 1 | Output enable for `misoOut` (slave role, `ssN` low) |
| ssN | input | 1 | Active-low slave select |

## Verification
The master role is exercised against a behavioural slave across all eight combinations of polarity, phase and bit order, each with its own byte pair. Asymmetric byte patterns make a swapped bit order or a wrong sampling edge show up as a corrupted byte rather than a lucky match. All eight rate settings are then run, and the measured SCK half-period separates the double-speed and normal dividers. The slave role is driven by a bench-generated clock in four mode combinations, plus a select pulse that is dropped mid-byte. That case separates a bit counter that restarts from one that carries over. Flag tests compare clearing by status-then-data against a data access alone, against interrupt acknowledge, and against a collision and a mode fault.

// File: rtl/spi_duplex_pkg.sv
package spi_duplex_pkg;

  // strobes issued by the control unit to the shift datapath
  typedef struct packed {
    logic load;    // take a new transmit byte
    logic sample;  // shift in one received bit
    logic setup;   // present the next transmit bit
    logic finish;  // byte complete, capture receive buffer
  } xferStb_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // width of the half-period divider (half-period up to 64 cycles)
  localparam int DIV_W = 7;

  // log2 of the SCK half-period in clk cycles
  function automatic logic [2:0] halfExp(input logic dbl, input logic [1:0] rate);
    logic [2:0] base;
    case (rate)
      2'd0:    base = 3'd1;
      2'd1:    base = 3'd3;
      2'd2:    base = 3'd5;
      default: base = 3'd6;
    endcase
    return base - {2'b00, dbl};
  endfunction

endpackage

// File: rtl/spi_duplex_ctrl.sv
module spi_duplex_ctrl
  import spi_duplex_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [6:0]        cfgWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [DATA_W-1:0] rxBuf,
  input  logic              irqAck,
  output logic              irq,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              misoIn,
  input  logic              ssN,
  output logic              sckOut,
  output logic              sckOe,
  output logic              mosiOe,
  output logic              misoOe,
  output logic              serIn,
  output logic              lsbFirst,
  output xferStb_t          stb
);

  localparam int EDGES     = 2 * DATA_W;
  localparam int EDGE_W    = $clog2(EDGES);
  localparam int LAST_EDGE = EDGES - 1;

  // configuration
  logic       cpha, cpol, master, irqEn, dbl;
  logic [1:0] rate;

  // input synchronizers
  logic [SYNC_STAGES-1:0] sckSh, mosiSh, ssSh;
  logic sckSync, mosiSync, ssSync;

  // transfer state
  logic              mBusy, sckLvl, prevLvl;
  logic [DIV_W-1:0]  divCnt, halfM1;
  logic [EDGE_W-1:0] edgeCnt;

  // flags
  logic doneFlag, doneArm, collFlag, collArm;

  // decoded accesses and events
  logic wrCtrl, wrStat, wrData, rdStat, rdData, dataAcc;
  logic xferActive, startXfer, faultEv, finishEv;
  logic mTick, sTick, tick, lastEdge, sampleEdge, slvLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSh  <= '0;
      mosiSh <= '0;
      ssSh   <= '1;
    end else begin
      sckSh  <= {sckSh[SYNC_STAGES-2:0], sckIn};
      mosiSh <= {mosiSh[SYNC_STAGES-2:0], mosiIn};
      ssSh   <= {ssSh[SYNC_STAGES-2:0], ssN};
    end
  end

  assign sckSync  = sckSh[SYNC_STAGES-1];
  assign mosiSync = mosiSh[SYNC_STAGES-1];
  assign ssSync   = ssSh[SYNC_STAGES-1];

  always_comb begin
    wrCtrl  = regWr && (regAddr == ADDR_CTRL);
    wrStat  = regWr && (regAddr == ADDR_STAT);
    wrData  = regWr && (regAddr == ADDR_DATA);
    rdStat  = regRd && (regAddr == ADDR_STAT);
    rdData  = regRd && (regAddr == ADDR_DATA);
    dataAcc = wrData || rdData;

    xferActive = master ? mBusy : !ssSync;
    startXfer  = wrData && master && !mBusy;
    faultEv    = master && !ssSync;

    halfM1   = DIV_W'((32'd1 << halfExp(dbl, rate)) - 32'd1);
    slvLvl   = sckSync ^ cpol;
    mTick    = master && mBusy && (divCnt == halfM1);
    sTick    = !master && !ssSync && (slvLvl != prevLvl);
    tick     = mTick || sTick;
    lastEdge = (edgeCnt == EDGE_W'(LAST_EDGE));
    // even edge count = leading edge; phase bit swaps sample and setup
    sampleEdge = (!edgeCnt[0]) ^ cpha;
    finishEv   = tick && lastEdge;

    stb.load   = wrData && !xferActive;
    stb.sample = tick && sampleEdge;
    stb.setup  = tick && !sampleEdge;
    stb.finish = finishEv;
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpha <= 1'b0; cpol <= 1'b0; master <= 1'b0; lsbFirst <= 1'b0;
      irqEn <= 1'b0; rate <= 2'd0; dbl <= 1'b0;
    end else begin
      if (wrCtrl) begin
        cpha     <= cfgWdata[0];
        cpol     <= cfgWdata[1];
        lsbFirst <= cfgWdata[3];
        irqEn    <= cfgWdata[4];
        rate     <= cfgWdata[6:5];
      end
      if (faultEv)     master <= 1'b0;
      else if (wrCtrl) master <= cfgWdata[2];
      if (wrStat) dbl <= cfgWdata[2];
    end
  end

  // master clock generation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy  <= 1'b0;
      sckLvl <= 1'b0;
      divCnt <= '0;
    end else if (faultEv || !master) begin
      mBusy  <= 1'b0;
      sckLvl <= 1'b0;
      divCnt <= '0;
    end else if (startXfer) begin
      mBusy  <= 1'b1;
      sckLvl <= 1'b0;
      divCnt <= '0;
    end else if (mBusy) begin
      if (divCnt == halfM1) begin
        divCnt <= '0;
        sckLvl <= ~sckLvl;
        if (lastEdge) mBusy <= 1'b0;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // edge counter shared by both roles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
      prevLvl <= 1'b0;
    end else begin
      prevLvl <= slvLvl;
      if (startXfer || faultEv || (!master && ssSync)) edgeCnt <= '0;
      else if (tick) edgeCnt <= lastEdge ? '0 : edgeCnt + 1'b1;
    end
  end

  // status flags with read-status-then-data clearing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0; doneArm <= 1'b0;
      collFlag <= 1'b0; collArm <= 1'b0;
    end else begin
      if (finishEv || faultEv)                  doneFlag <= 1'b1;
      else if (irqAck || (dataAcc && doneArm))  doneFlag <= 1'b0;

      if (rdStat && doneFlag)       doneArm <= 1'b1;
      else if (dataAcc || irqAck)   doneArm <= 1'b0;

      if (wrData && xferActive)     collFlag <= 1'b1;
      else if (dataAcc && collArm)  collFlag <= 1'b0;

      if (rdStat && collFlag)       collArm <= 1'b1;
      else if (dataAcc)             collArm <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdata = DATA_W'({1'b0, rate, irqEn, lsbFirst, master, cpol, cpha});
      ADDR_STAT: regRdata = DATA_W'({5'b0, dbl, collFlag, doneFlag});
      ADDR_DATA: regRdata = rxBuf;
      default:   regRdata = '0;
    endcase
  end

  assign irq    = doneFlag && irqEn;
  assign sckOut = cpol ^ sckLvl;
  assign sckOe  = master;
  assign mosiOe = master;
  assign misoOe = !master && !ssN;
  assign serIn  = master ? misoIn : mosiSync;

  // R1
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mBusy |-> (sckLvl == 1'b0));

  // R6
  done_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(finishEv || faultEv));

  // R7
  coll_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrData && xferActive) |=> collFlag);

  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !finishEv && !faultEv) |=> !doneFlag);

  // R10
  fault_demote_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultEv |=> (!master && !mBusy));

  // R11
  slave_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!master && ssSync) |=> (edgeCnt == '0));

endmodule

// File: rtl/spi_duplex_datapath.sv
module spi_duplex_datapath
  import spi_duplex_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStb_t          stb,
  input  logic              serIn,
  input  logic              lsbFirst,
  input  logic [DATA_W-1:0] txByte,
  output logic              serOut,
  output logic [DATA_W-1:0] rxBuf
);

  logic [DATA_W-1:0] shiftReg, shifted;

  always_comb begin
    if (lsbFirst) shifted = {serIn, shiftReg[DATA_W-1:1]};
    else          shifted = {shiftReg[DATA_W-2:0], serIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      serOut   <= 1'b0;
      rxBuf    <= '0;
    end else begin
      if (stb.load) begin
        shiftReg <= txByte;
        serOut   <= lsbFirst ? txByte[0] : txByte[DATA_W-1];
      end else begin
        if (stb.sample) shiftReg <= shifted;
        if (stb.setup)  serOut   <= lsbFirst ? shiftReg[0] : shiftReg[DATA_W-1];
      end
      if (stb.finish) rxBuf <= stb.sample ? shifted : shiftReg;
    end
  end

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.load, stb.sample, stb.setup}));

  // R5
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.finish |=> $stable(rxBuf));

endmodule

// File: rtl/spi_duplex_unit.sv
module spi_duplex_unit
  import spi_duplex_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              irqAck,
  output logic              irq,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              ssN
);

  xferStb_t          stb;
  logic              serIn, serOut, lsbFirst;
  logic [DATA_W-1:0] rxBuf;

  spi_duplex_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWr    (regWr),
    .regRd    (regRd),
    .cfgWdata (regWdata[6:0]),
    .regRdata (regRdata),
    .rxBuf    (rxBuf),
    .irqAck   (irqAck),
    .irq      (irq),
    .sckIn    (sckIn),
    .mosiIn   (mosiIn),
    .misoIn   (misoIn),
    .ssN      (ssN),
    .sckOut   (sckOut),
    .sckOe    (sckOe),
    .mosiOe   (mosiOe),
    .misoOe   (misoOe),
    .serIn    (serIn),
    .lsbFirst (lsbFirst),
    .stb      (stb)
  );

  spi_duplex_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .serIn    (serIn),
    .lsbFirst (lsbFirst),
    .txByte   (regWdata),
    .serOut   (serOut),
    .rxBuf    (rxBuf)
  );

  assign mosiOut = serOut;
  assign misoOut = serOut;

endmodule

// File: tb/tb_spi_duplex_unit.sv
module tb_spi_duplex_unit;

  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWr = 1'b0, regRd = 1'b0, irqAck = 1'b0;
  logic [7:0] regWdata = 8'h00, regRdata;
  logic       irq, sckOut, sckOe, mosiOut, mosiOe, misoOut, misoOe;
  logic       sckIn = 1'b0, mosiIn = 1'b0, misoIn = 1'b0, ssN = 1'b1;

  always #4 clk = ~clk;

  spi_duplex_unit dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .irqAck(irqAck), .irq(irq),
    .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe), .mosiIn(mosiIn),
    .mosiOut(mosiOut), .mosiOe(mosiOe), .misoIn(misoIn), .misoOut(misoOut),
    .misoOe(misoOe), .ssN(ssN)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRd = 1'b1; #1 d = regRdata;
    @(negedge clk); regRd = 1'b0;
  endtask

  // ---------------- behavioural slave + monitor (master-role tests)
  logic       mdlOn = 1'b0, mdlCpol = 1'b0, mdlCpha = 1'b0, mdlLsb = 1'b0, mdlPrev = 1'b0;
  logic [7:0] mdlTx = 8'h00, mdlRx = 8'h00;
  int         mdlSamp = 0, mdlSetup = 0, mdlSince = 0, mdlHalf = 0;
  logic [7:0] expMosi[$];

  function automatic int bitIdx(input logic lsb, input int i);
    return lsb ? i : 7 - i;
  endfunction

  always @(negedge clk) begin : slaveModel
    logic lvl;
    int   j;
    logic [7:0] e;
    if (mdlOn) begin
      lvl = sckOut ^ mdlCpol;
      mdlSince++;
      if (lvl !== mdlPrev) begin
        mdlHalf  = mdlSince;
        mdlSince = 0;
        mdlPrev  = lvl;
        if (lvl ^ mdlCpha) begin
          if (mdlSamp < 8) mdlRx[bitIdx(mdlLsb, mdlSamp)] = mosiOut;
          mdlSamp++;
          if (mdlSamp == 8) begin
            if (expMosi.size() == 0) chk("R5 unexpected byte on mosi", 32'(mdlRx), 32'hFFFF);
            else begin
              e = expMosi.pop_front();
              chk("R2/R4/R7 byte seen on mosi", 32'(mdlRx), 32'(e));
            end
          end
        end else begin
          j = mdlCpha ? mdlSetup : mdlSetup + 1;
          if (j < 8) misoIn = mdlTx[bitIdx(mdlLsb, j)];
          mdlSetup++;
        end
      end
    end
  end

  task automatic cfgMaster(input logic pol, input logic pha, input logic lsb,
                           input logic [1:0] rate, input logic dbl, input logic ie);
    busWrite(A_STAT, {5'b0, dbl, 2'b0});
    busWrite(A_CTRL, {1'b0, rate, ie, lsb, 1'b1, pol, pha});
    mdlCpol = pol; mdlCpha = pha; mdlLsb = lsb;
  endtask

  task automatic mdlStart(input logic [7:0] tx, input logic [7:0] sl);
    mdlTx = sl; mdlRx = 8'h00; mdlSamp = 0; mdlSetup = 0; mdlSince = 0; mdlPrev = 1'b0;
    misoIn = sl[bitIdx(mdlLsb, 0)];
    expMosi.push_back(tx);
    mdlOn = 1'b1;
  endtask

  task automatic waitDone(output logic [7:0] st);
    for (int i = 0; i < 1500; i++) begin
      busRead(A_STAT, st);
      if (st[0]) break;
    end
  endtask

  task automatic masterXfer(input logic [7:0] tx, input logic [7:0] sl,
                            input int expHalf, input string tag);
    logic [7:0] st, rx;
    mdlStart(tx, sl);
    busWrite(A_DATA, tx);
    waitDone(st);
    chk({"R6 done flag ", tag}, 32'(st[0]), 32'd1);
    busRead(A_DATA, rx);
    chk({"R5 received byte ", tag}, 32'(rx), 32'(sl));
    chk({"R1 sck idle after ", tag}, 32'(sckOut), 32'(mdlCpol));
    if (expHalf > 0) chk({"R3 half period ", tag}, 32'(mdlHalf), 32'(expHalf));
    mdlOn = 1'b0;
  endtask

  // ---------------- bench-driven master for slave-role tests
  task automatic slaveXfer(input logic [7:0] pre, input logic [7:0] mo,
                           input logic pol, input logic pha, input logic lsb,
                           input string tag);
    logic [7:0] cap, st, rx;
    int sCnt, uCnt, j;
    cap = 8'h00; sCnt = 0; uCnt = 0;
    busWrite(A_CTRL, {3'b0, 1'b0, lsb, 1'b0, pol, pha});
    busWrite(A_DATA, pre);
    sckIn = pol;
    mosiIn = pha ? 1'b0 : mo[bitIdx(lsb, 0)];
    repeat (4) @(negedge clk);
    ssN = 1'b0;
    repeat (8) @(negedge clk);
    for (int e = 0; e < 16; e++) begin
      if (((e % 2) == 0) != pha) begin
        cap[bitIdx(lsb, sCnt)] = misoOut;
        sCnt++;
        sckIn = ~sckIn;
      end else begin
        sckIn = ~sckIn;
        j = pha ? uCnt : uCnt + 1;
        if (j < 8) mosiIn = mo[bitIdx(lsb, j)];
        uCnt++;
      end
      repeat (8) @(negedge clk);
    end
    ssN = 1'b1;
    repeat (6) @(negedge clk);
    chk({"R2/R4 slave miso byte ", tag}, 32'(cap), 32'(pre));
    busRead(A_STAT, st);
    chk({"R6 slave done ", tag}, 32'(st[0]), 32'd1);
    busRead(A_DATA, rx);
    chk({"R2/R4 slave received ", tag}, 32'(rx), 32'(mo));
  endtask

  function automatic int halfFor(input logic dbl, input int r);
    int base;
    case (r)
      0: base = 1;
      1: base = 3;
      2: base = 5;
      default: base = 6;
    endcase
    return 1 << (base - int'(dbl));
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin : mainSeq
    logic [7:0] st, rx, cr;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R12 reset state
    busRead(A_CTRL, cr);  chk("R12 control after reset", 32'(cr), 32'd0);
    busRead(A_STAT, st);  chk("R12 status after reset", 32'(st), 32'd0);
    chk("R12 irq after reset", 32'(irq), 32'd0);
    chk("R1 sckOe in slave role", 32'(sckOe), 32'd0);

    // R1 R2 R4 R5 R6: all mode combinations in master role
    for (int m = 0; m < 8; m++) begin
      cfgMaster(m[0], m[1], m[2], 2'd0, 1'b0, 1'b0);
      chk("R1 sck idle level", 32'(sckOut), 32'(m[0]));
      chk("R1 sckOe in master role", 32'(sckOe), 32'd1);
      masterXfer(8'h3C ^ 8'(m * 37), 8'hA1 + 8'(m * 23), 2, $sformatf("mode %0d", m));
    end

    // R3: every rate setting
    for (int d = 0; d < 2; d++) begin
      for (int r = 0; r < 4; r++) begin
        cfgMaster(1'b0, 1'b1, 1'b0, 2'(r), d[0], 1'b0);
        masterXfer(8'hB4 + 8'(r), 8'h69 - 8'(d), halfFor(d[0], r),
                   $sformatf("dbl %0d rate %0d", d, r));
      end
    end

    // R9: interrupt when enabled
    cfgMaster(1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1);
    mdlStart(8'h5A, 8'hC3);
    busWrite(A_DATA, 8'h5A);
    repeat (40) @(negedge clk);
    chk("R9 irq with enable set", 32'(irq), 32'd1);
    busRead(A_STAT, st);
    busRead(A_DATA, rx);
    chk("R9 irq after clear sequence", 32'(irq), 32'd0);
    mdlOn = 1'b0;

    // R8: data access without status read leaves flag; R9 irq masked
    cfgMaster(1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0);
    mdlStart(8'h81, 8'h7E);
    busWrite(A_DATA, 8'h81);
    repeat (40) @(negedge clk);
    chk("R9 irq masked by enable", 32'(irq), 32'd0);
    busRead(A_DATA, rx);
    chk("R5 read returns receive buffer", 32'(rx), 32'h7E);
    busRead(A_STAT, st);
    chk("R8 flag kept without prior status read", 32'(st[0]), 32'd1);
    busRead(A_DATA, rx);
    busRead(A_STAT, st);
    chk("R8 flag cleared by status then data", 32'(st[0]), 32'd0);
    mdlOn = 1'b0;

    // R7 collision
    cfgMaster(1'b0, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0);
    mdlStart(8'hE2, 8'h1D);
    busWrite(A_DATA, 8'hE2);
    repeat (20) @(negedge clk);
    busWrite(A_DATA, 8'h00);
    busRead(A_STAT, st);
    chk("R7 collision flag set", 32'(st[1]), 32'd1);
    waitDone(st);
    busRead(A_DATA, rx);
    chk("R7 transfer unaffected by late write", 32'(rx), 32'h1D);
    busRead(A_STAT, st);
    chk("R8 both flags cleared", 32'(st[1:0]), 32'd0);
    mdlOn = 1'b0;

    // R10 mode fault, R9 acknowledge
    cfgMaster(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1);
    ssN = 1'b0;
    repeat (6) @(negedge clk);
    busRead(A_CTRL, cr);
    chk("R10 master bit cleared on fault", 32'(cr[2]), 32'd0);
    busRead(A_STAT, st);
    chk("R10 done set on fault", 32'(st[0]), 32'd1);
    chk("R10 irq on fault", 32'(irq), 32'd1);
    ssN = 1'b1;
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
    chk("R9 irqAck clears irq", 32'(irq), 32'd0);
    busRead(A_STAT, st);
    chk("R9 irqAck clears done", 32'(st[0]), 32'd0);

    // slave role, several modes
    slaveXfer(8'h96, 8'h4B, 1'b0, 1'b0, 1'b0, "pol0 pha0 msb");
    slaveXfer(8'h2D, 8'hE8, 1'b1, 1'b1, 1'b1, "pol1 pha1 lsb");
    slaveXfer(8'hC1, 8'h37, 1'b0, 1'b1, 1'b0, "pol0 pha1 msb");
    slaveXfer(8'h5E, 8'hA9, 1'b1, 1'b0, 1'b1, "pol1 pha0 lsb");

    // R11: select dropped mid-byte
    busWrite(A_CTRL, 8'h00);
    sckIn = 1'b0; mosiIn = 1'b1;
    ssN = 1'b0;
    repeat (8) @(negedge clk);
    for (int e = 0; e < 6; e++) begin
      sckIn = ~sckIn;
      repeat (8) @(negedge clk);
    end
    ssN = 1'b1;
    repeat (8) @(negedge clk);
    busRead(A_STAT, st);
    chk("R11 partial byte sets no flag", 32'(st[0]), 32'd0);
    slaveXfer(8'h0F, 8'hD2, 1'b0, 1'b0, 1'b0, "after partial R11");

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule